// File: doc/BRIEF.md
# SONET Frame Alignment and Loss-of-Frame Monitor

This block sits behind a byte-aligned STS-3c receive path. It watches the incoming byte stream for the framing word: three A1 bytes followed by three A2 bytes. It keeps a counter that gives the position of each byte within the frame and raises a row indication while the first overhead row of each frame passes. From the same counter it derives the out-of-frame (OOF) and loss-of-frame (LOF) conditions. A sticky change flag goes with each condition, and the consumer clears that flag by pulsing an input.

The control is a two-state machine. In SEARCH the block reports OOF. In SYNC it is in frame. There are four transitions:
- **acquire (SEARCH to SYNC)**: a complete framing word at any byte alignment, or, in bypass, a rising edge of the external strobe.
- **lose (SYNC to SEARCH)**: the fifth consecutive frame whose framing word holds a bit error.
- **re-anchor (SYNC to SYNC)**: a strobe edge in bypass.
- **hold**: every other case.

A separate integrator turns OOF into LOF. It uses equal 24-frame windows to set LOF and to clear it.

Bypass mode serves systems where an external framer already knows the frame boundary. In bypass the byte search is off, and the position counter follows the strobe. All state advances only on byte times, which are cycles with the byte enable high.

Top module: `frm_align_mon`

## Requirements
- R1: After reset, oof reads 1 and lof, oof_delta, lof_delta and sof_row read 0.
- R2: While out of frame and not in bypass, a byte time that completes the sequence F6 F6 F6 28 28 28 (hex, in arrival order) clears oof from the next cycle, at any byte alignment. The byte that follows the last 28 is frame position 6.
- R3: While in frame, sof_row is 1 for frame positions 0 to ROW_LEN-1 and 0 for the rest. Position 0 returns every FRAME_LEN byte times. While oof is 1, sof_row is 0.
- R4: In frame, the six bytes that end at position 5 are checked against the framing word. The fifth consecutive failed check sets oof. A passing check restarts the count of failed checks.
- R5: lof is set when oof has been 1 at LOF_FRAMES (24) consecutive frame boundaries. A frame boundary is a byte time at position FRAME_LEN-1.
- R6: lof is cleared when oof has been 0 at 24 consecutive frame boundaries. Any byte time in which oof equals lof restarts the count.
- R7: oof_delta and lof_delta become 1 in the cycle their condition changes and stay 1 until the matching clear input is 1. A change in the same cycle as a clear leaves the flag at 1.
- R8: A cycle with byte_en low does not change frame position, oof, lof or the search history.
- R9: When ext_mode is 1, a 0-to-1 change of ext_sof seen at a byte time makes that byte frame position 0 and enters or stays in frame, and the byte search is disabled. When ext_mode is 0, ext_sof has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | Qualifies rx_byte as a valid byte time |
| rx_byte | input | 8 | Received byte-aligned data |
| ext_mode | input | 1 | 1 selects external strobe alignment instead of the search |
| ext_sof | input | 1 | External start-of-frame strobe, used on its rising edge |
| oof_delta_clr | input | 1 | Pulse high to clear oof_delta |
| lof_delta_clr | input | 1 | Pulse high to clear lof_delta |
| oof | output | 1 | Out-of-frame condition |
| lof | output | 1 | Loss-of-frame condition |
| oof_delta | output | 1 | Sticky flag: oof changed |
| lof_delta | output | 1 | Sticky flag: lof changed |
| sof_row | output | 1 | High during the first row of each frame |

## Verification
The hardest case to reach from the ports is an LOF clear window that an OOF excursion interrupts. The bench has to produce one full LOF set, then return in frame for part of the window. It then corrupts five framing words in a row so that OOF returns, and only then allows a full clean window. A scoreboard model tracks position, error count and integrator count for every byte time, so the restart of the count shows up as the exact cycle at which lof falls. Strobe alignment at a position that is not a framing word also shows whether bypass truly keeps the byte search out of the loop.

// File: rtl/frm_align_pkg.sv
package frm_align_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_SYNC   = 1'b1
    } frm_state_e;

    localparam int FRM_NA = 3;
    localparam logic [7:0] FRM_A1 = 8'hF6;
    localparam logic [7:0] FRM_A2 = 8'h28;
endpackage

// File: rtl/frm_pattern_det.sv
module frm_pattern_det #(
    parameter int          NA      = 3,
    parameter logic [7:0]  A1_BYTE = 8'hF6,
    parameter logic [7:0]  A2_BYTE = 8'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic [7:0] rx_byte,
    output logic       match
);
    localparam int LEN = 2 * NA;

    logic [7:0]     hist_q [LEN-1];
    logic [LEN-1:0] hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LEN - 1; k++) hist_q[k] <= '0;
        end else if (byte_en) begin
            hist_q[0] <= rx_byte;
            for (int k = 1; k < LEN - 1; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    // index i is the arrival order of the word; the last entry is the live byte
    for (genvar i = 0; i < LEN; i++) begin : g_cmp
        localparam logic [7:0] WANT = (i < NA) ? A1_BYTE : A2_BYTE;
        if (i == LEN - 1) begin : g_live
            assign hit[i] = (rx_byte == WANT);
        end else begin : g_hist
            assign hit[i] = (hist_q[LEN-2-i] == WANT);
        end
    end

    assign match = &hit;
endmodule

// File: rtl/frm_pos_ctr.sv
module frm_pos_ctr #(
    parameter int FRAME_LEN = 2430,
    localparam int PW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_en,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] pos,
    output logic          at_last
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

    logic [PW-1:0] pos_q;

    assign at_last = (pos_q == LAST);
    assign pos     = pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (byte_en) pos_q <= load ? load_val : (at_last ? '0 : pos_q + 1'b1);
    end

    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(pos_q));
endmodule

// File: rtl/frm_lof_integ.sv
module frm_lof_integ #(
    parameter int LOF_FRAMES = 24,
    localparam int CW = $clog2(LOF_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oof,
    output logic lof,
    output logic flip
);
    localparam logic [CW-1:0] TOP = CW'(LOF_FRAMES - 1);

    logic          lof_q;
    logic [CW-1:0] cnt_q;

    assign flip = tick && (oof != lof_q) && (cnt_q == TOP);
    assign lof  = lof_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lof_q <= 1'b0;
            cnt_q <= '0;
        end else if (oof == lof_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == TOP) begin
                cnt_q <= '0;
                lof_q <= ~lof_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    p_lof_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof_q) |-> $past(oof));
    p_lof_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof_q) |-> !$past(oof));
endmodule

// File: rtl/frm_align_mon.sv
module frm_align_mon
    import frm_align_pkg::*;
#(
    parameter int FRAME_LEN      = 2430,
    parameter int ROW_LEN        = 270,
    parameter int OOF_BAD_FRAMES = 5,
    parameter int LOF_FRAMES     = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic [7:0] rx_byte,
    input  logic       ext_mode,
    input  logic       ext_sof,
    input  logic       oof_delta_clr,
    input  logic       lof_delta_clr,
    output logic       oof,
    output logic       lof,
    output logic       oof_delta,
    output logic       lof_delta,
    output logic       sof_row
);
    localparam int PW = $clog2(FRAME_LEN);
    localparam int BW = $clog2(OOF_BAD_FRAMES + 1);
    localparam logic [PW-1:0] ANCHOR_POS = PW'(2 * FRM_NA);
    localparam logic [PW-1:0] CHECK_POS  = PW'(2 * FRM_NA - 1);
    localparam logic [PW-1:0] STROBE_POS = PW'(1);
    localparam logic [PW-1:0] ROW_LIM    = PW'(ROW_LEN);
    localparam logic [BW-1:0] BAD_LAST   = BW'(OOF_BAD_FRAMES - 1);

    frm_state_e    state, state_n;
    logic [BW-1:0] bad_q, bad_n;
    logic          ext_prev_q;
    logic          match, at_last, load, lof_flip, ext_rise;
    logic [PW-1:0] pos, load_val;
    logic          oof_delta_q, lof_delta_q;

    frm_pattern_det #(.NA(FRM_NA), .A1_BYTE(FRM_A1), .A2_BYTE(FRM_A2)) u_det (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .rx_byte(rx_byte), .match(match)
    );

    frm_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .load(load),
        .load_val(load_val), .pos(pos), .at_last(at_last)
    );

    frm_lof_integ #(.LOF_FRAMES(LOF_FRAMES)) u_lof (
        .clk(clk), .rst_n(rst_n), .tick(byte_en && at_last), .oof(oof),
        .lof(lof), .flip(lof_flip)
    );

    assign ext_rise = ext_mode && ext_sof && !ext_prev_q;

    // next-state logic
    always_comb begin
        state_n  = state;
        bad_n    = bad_q;
        load     = 1'b0;
        load_val = '0;
        if (byte_en) begin
            unique case (state)
                ST_SEARCH: begin
                    if (ext_rise) begin
                        state_n  = ST_SYNC;
                        load     = 1'b1;
                        load_val = STROBE_POS;
                        bad_n    = '0;
                    end else if (!ext_mode && match) begin
                        state_n  = ST_SYNC;
                        load     = 1'b1;
                        load_val = ANCHOR_POS;
                        bad_n    = '0;
                    end
                end
                ST_SYNC: begin
                    if (ext_rise) begin
                        load     = 1'b1;
                        load_val = STROBE_POS;
                        bad_n    = '0;
                    end else if (pos == CHECK_POS) begin
                        if (match) begin
                            bad_n = '0;
                        end else if (bad_q == BAD_LAST) begin
                            state_n = ST_SEARCH;
                            bad_n   = '0;
                        end else begin
                            bad_n = bad_q + 1'b1;
                        end
                    end
                end
                default: state_n = ST_SEARCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SEARCH;
            bad_q      <= '0;
            ext_prev_q <= 1'b0;
        end else begin
            state <= state_n;
            bad_q <= bad_n;
            if (byte_en) ext_prev_q <= ext_sof;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oof_delta_q <= 1'b0;
            lof_delta_q <= 1'b0;
        end else begin
            if (state_n != state) oof_delta_q <= 1'b1;
            else if (oof_delta_clr) oof_delta_q <= 1'b0;
            if (lof_flip) lof_delta_q <= 1'b1;
            else if (lof_delta_clr) lof_delta_q <= 1'b0;
        end
    end

    assign oof       = (state == ST_SEARCH);
    assign sof_row   = (state == ST_SYNC) && (pos < ROW_LIM);
    assign oof_delta = oof_delta_q;
    assign lof_delta = lof_delta_q;

    p_search_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && byte_en && !ext_mode && match) |=> (state == ST_SYNC));
    p_bad_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q <= BAD_LAST);
    p_oof_delta_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> oof_delta_q);
    p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && byte_en && !ext_mode && !match) |=> (state == ST_SEARCH));
endmodule

// File: tb/frm_align_mon_tb.sv
module frm_align_mon_tb_top;
    localparam int FL  = 48;
    localparam int RL  = 9;
    localparam int BAD = 5;
    localparam int LF  = 24;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_en = 1'b0;
    logic [7:0] rx_byte = '0;
    logic ext_mode = 1'b0;
    logic ext_sof = 1'b0;
    logic oof_delta_clr = 1'b0;
    logic lof_delta_clr = 1'b0;
    logic oof, lof, oof_delta, lof_delta, sof_row;

    always #4 clk = ~clk;

    frm_align_mon #(.FRAME_LEN(FL), .ROW_LEN(RL), .OOF_BAD_FRAMES(BAD), .LOF_FRAMES(LF)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .rx_byte(rx_byte),
        .ext_mode(ext_mode), .ext_sof(ext_sof), .oof_delta_clr(oof_delta_clr),
        .lof_delta_clr(lof_delta_clr), .oof(oof), .lof(lof), .oof_delta(oof_delta),
        .lof_delta(lof_delta), .sof_row(sof_row)
    );

    typedef struct {
        int unsigned cyc;
        logic [4:0]  exp;
        string       req;
    } sb_item_t;

    sb_item_t q[$];
    int unsigned cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference state, from the requirements
    logic m_oof = 1, m_lof = 0, m_od = 0, m_ld = 0, m_extp = 0;
    int   m_pos = 0, m_bad = 0, m_cnt = 0;
    logic [7:0] m_win [5] = '{default: 8'h00};
    logic tb_mode = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            sb_item_t it;
            logic [4:0] act;
            it  = q.pop_front();
            act = {oof, lof, oof_delta, lof_delta, sof_row};
            checks++;
            if (it.cyc != cyc || act !== it.exp) begin
                fails++;
                $display("FAIL %s cycle %0d: oof/lof/odelta/ldelta/row actual=%b expected=%b",
                         it.req, cyc, act, it.exp);
            end
        end
    end

    task automatic step(input logic en, input logic [7:0] b, input logic xs,
                        input logic co, input logic cl, input string req);
        logic match, tick, noof, nlof, flip, rise;
        int npos, nbad;
        sb_item_t it;
        @(posedge clk); #1;
        byte_en = en; rx_byte = b; ext_sof = xs; ext_mode = tb_mode;
        oof_delta_clr = co; lof_delta_clr = cl;
        match = (b == A2) && (m_win[0] == A2) && (m_win[1] == A2) &&
                (m_win[2] == A1) && (m_win[3] == A1) && (m_win[4] == A1);
        tick = en && (m_pos == FL - 1);
        noof = m_oof; nlof = m_lof; npos = m_pos; nbad = m_bad; flip = 0;
        if (en) begin
            rise = tb_mode && xs && !m_extp;
            npos = (m_pos == FL - 1) ? 0 : m_pos + 1;
            if (m_oof) begin
                if (rise) begin noof = 0; npos = 1; nbad = 0; end
                else if (!tb_mode && match) begin noof = 0; npos = 6; nbad = 0; end
            end else begin
                if (rise) begin npos = 1; nbad = 0; end
                else if (m_pos == 5) begin
                    if (match) nbad = 0;
                    else if (m_bad == BAD - 1) begin noof = 1; nbad = 0; end
                    else nbad = m_bad + 1;
                end
            end
            for (int k = 4; k > 0; k--) m_win[k] = m_win[k-1];
            m_win[0] = b;
            m_extp = xs;
        end
        if (m_oof == m_lof) m_cnt = 0;
        else if (tick) begin
            if (m_cnt == LF - 1) begin m_cnt = 0; nlof = ~m_lof; flip = 1; end
            else m_cnt++;
        end
        if (noof != m_oof) m_od = 1; else if (co) m_od = 0;
        if (flip) m_ld = 1; else if (cl) m_ld = 0;
        m_oof = noof; m_lof = nlof; m_pos = npos; m_bad = nbad;
        it.cyc = cyc + 1;
        it.exp = {m_oof, m_lof, m_od, m_ld, (!m_oof && m_pos < RL)};
        it.req = req;
        q.push_back(it);
    endtask

    // one frame: framing word (optionally corrupted), then filler
    task automatic send_frame(input bit bad, input int strobe_at, input bit gaps,
                              input logic co, input string req);
        for (int i = 0; i < FL; i++) begin
            logic [7:0] b;
            if (i < 3) b = A1;
            else if (i < 6) b = A2;
            else b = i[0] ? 8'h5A : 8'hA5;
            if (bad && i == 4) b = b ^ 8'h01;
            if (gaps && (i % 5 == 2)) step(0, 8'hF6, 1, co, 0, req);
            step(1, b, (strobe_at >= 0 && i >= strobe_at && i < strobe_at + 3), co, 0, req);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if ({oof, lof, oof_delta, lof_delta, sof_row} !== 5'b10000) begin
            fails++;
            $display("FAIL R1 reset: actual=%b expected=%b",
                     {oof, lof, oof_delta, lof_delta, sof_row}, 5'b10000);
        end
        // R8: idle cycles before any data
        repeat (3) step(0, A1, 0, 0, 0, "R8");
        // R2: acquisition at an odd alignment
        repeat (3) step(1, 8'h33, 0, 0, 0, "R2");
        send_frame(0, -1, 0, 0, "R2");
        repeat (2) send_frame(0, -1, 0, 0, "R3");
        // R7: clear the change flag
        step(0, 8'h00, 0, 1, 0, "R7");
        // R8: byte_en gaps inside frames
        repeat (2) send_frame(0, -1, 1, 0, "R8");
        // R4: four errored frames, a clean one, four more: still in frame
        repeat (4) send_frame(1, -1, 0, 0, "R4");
        send_frame(0, -1, 0, 0, "R4");
        repeat (4) send_frame(1, -1, 0, 0, "R4");
        send_frame(0, -1, 0, 0, "R4");
        // R4 + R7: five errored frames with the clear held: flag still set
        repeat (5) send_frame(1, -1, 0, 1, "R7");
        // R5: integrate OOF into LOF
        repeat (26) send_frame(1, -1, 0, 0, "R5");
        step(0, 8'h00, 0, 0, 1, "R7");
        // R6: partial clear window broken by a new OOF, then a full window
        repeat (8) send_frame(0, -1, 0, 0, "R6");
        repeat (6) send_frame(1, -1, 0, 0, "R6");
        repeat (27) send_frame(0, -1, 0, 0, "R6");
        // R9: strobe ignored when not in bypass
        send_frame(0, 20, 0, 0, "R9");
        // R9: bypass, misaligned strobe re-anchors, checks then fail
        tb_mode = 1;
        send_frame(0, 20, 0, 0, "R9");
        repeat (6) send_frame(0, -1, 0, 0, "R9");
        // R9: framing word present but search disabled in bypass
        repeat (2) send_frame(0, -1, 0, 0, "R9");
        // R9: aligned strobe restores frame
        repeat (3) send_frame(0, 0, 0, 0, "R9");
        tb_mode = 0;
        repeat (3) step(1, 8'h00, 0, 0, 0, "R3");
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule